// File: doc/BRIEF.md
# Single-Precision Pair to 6-bit / 4-bit Float Converter

The block turns two IEEE single-precision operands into two small floating-point codes and packs them into one 16-bit word. At run time a selector picks the destination format. E2M3 has 2 exponent bits, 3 mantissa bits and bias 1. E3M2 has 3 exponent bits, 2 mantissa bits and bias 3. E2M1 has 2 exponent bits, 1 mantissa bit and bias 1. None of these formats can encode infinity or NaN. Results are always saturated: an over-range value becomes the largest finite code. An optional rectifier forces negative results to zero.

In the same cycle the block also widens a packed pair of codes back into two half-precision values. It uses the same lane placement as the narrowing path. Every value of a small format is representable in half precision, so the widening path is exact.

Each result is registered. A result appears one cycle after the input strobe and stays on the outputs until the next strobe.

Top module: `fp_narrow_pack`

## Requirements
- R1: `out_valid` is high in exactly the cycles that follow a cycle with `in_valid` high. `pk_out`, `half_a` and `half_b` change only one cycle after an `in_valid` cycle.
- R2: `fmt` selects the format: 0 is E2M3, 1 is E3M2. In these 6-bit modes `pk_out[13:8]` holds the code from `src_a` and `pk_out[5:0]` holds the code from `src_b`. Bits [15:14] and [7:6] are zero. Each code is {sign, exponent, mantissa} with the sign at bit 5.
- R3: `fmt` 2 selects E2M1, and `fmt` 3 acts the same as 2. In this mode `pk_out[15:8]` is zero, `pk_out[7:4]` holds the code from `src_a` and `pk_out[3:0]` holds the code from `src_b`. Each nibble is {sign, exponent, mantissa} with the sign at bit 3.
- R4: Narrowing rounds to nearest with ties to even. This holds for subnormal codes (exponent field 0) too, and a subnormal may round up into the smallest normal.
- R5: A magnitude above the largest finite value (7.5 for E2M3, 28 for E3M2, 6 for E2M1) gives the largest finite code with the input's sign. An infinity is treated the same way.
- R6: A NaN input, of either sign, gives the positive largest finite code.
- R7: When `relu` is high, every negative result becomes positive zero. This covers negative zero, negative infinity, and negative codes on the widening path.
- R8: The widening path decodes the codes in `pk_in` at the lane positions of R2 and R3 and returns exact half-precision values: the `src_a` lane on `half_a` and the `src_b` lane on `half_b`. The pad bits of `pk_in` are ignored.
- R9: Zeros and single-precision subnormals give a zero code that keeps the input's sign, unless R7 applies.
- R10: With `rst` high at a clock edge, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands valid strobe |
| fmt | input | 2 | Format selector |
| relu | input | 1 | Force negative results to zero |
| src_a | input | 32 | First single-precision operand |
| src_b | input | 32 | Second single-precision operand |
| pk_in | input | 16 | Packed code pair to widen |
| out_valid | output | 1 | Registered results valid |
| pk_out | output | 16 | Packed narrowed pair |
| half_a | output | 16 | Widened code from the upper lane |
| half_b | output | 16 | Widened code from the lower lane |

## Verification
The top has no tunable parameters. The bench builds the block in its only configuration and reaches every format, including the alias code 3, through the runtime selector, with `relu` both low and high. Directed operands sit on rounding ties, on the saturation edge just above each largest value, on NaN and infinity of both signs, and on signed and subnormal zeros. Random operands with exponents near the formats' range, together with random packed words, drive both paths at once.

// File: rtl/fpn_pkg.sv
package fpn_pkg;

    localparam int SP_W     = 32;
    localparam int SP_EXP_W = 8;
    localparam int SP_MAN_W = 23;
    localparam int HP_W     = 16;
    localparam int HP_EXP_W = 5;
    localparam int HP_MAN_W = 10;
    localparam int MAG_W    = 5;
    localparam int WORD_W   = 16;
    localparam int LANES    = 2;
    localparam int SCALE_W  = 10;

    typedef enum logic [1:0] {
        FMT_E2M3 = 2'd0,
        FMT_E3M2 = 2'd1,
        FMT_E2M1 = 2'd2,
        FMT_E2M1_ALIAS = 2'd3
    } fmt_e;

    typedef struct packed {
        logic                 sign;
        logic [SP_EXP_W-1:0]  exp;
        logic [SP_MAN_W-1:0]  man;
    } sp_t;

    typedef struct packed {
        logic              sign;
        logic [MAG_W-1:0]  mag;
    } nar_t;

    typedef struct packed {
        logic                        six;
        logic [1:0]                  mbits;
        logic signed [SCALE_W-1:0]   emin;
        logic signed [SCALE_W-1:0]   emax;
        logic [MAG_W-1:0]            maxmag;
        logic [HP_EXP_W-1:0]         hoff;
    } fmt_desc_t;

    function automatic fmt_desc_t fmt_desc(fmt_e f);
        fmt_desc_t d;
        case (f)
            FMT_E2M3: d = '{six: 1'b1, mbits: 2'd3, emin: 10'sd0,  emax: 10'sd2,
                            maxmag: 5'h1F, hoff: 5'd12};
            FMT_E3M2: d = '{six: 1'b1, mbits: 2'd2, emin: -10'sd2, emax: 10'sd4,
                            maxmag: 5'h1F, hoff: 5'd11};
            default:  d = '{six: 1'b0, mbits: 2'd1, emin: 10'sd0,  emax: 10'sd2,
                            maxmag: 5'h07, hoff: 5'd14};
        endcase
        return d;
    endfunction

    function automatic logic [3:0] msb_pos(logic [HP_MAN_W-1:0] v);
        logic [3:0] p;
        p = 4'd0;
        for (int i = 0; i < HP_MAN_W; i++) begin
            if (v[i]) p = 4'(i);
        end
        return p;
    endfunction

endpackage

// File: rtl/fpn_down_lane.sv
module fpn_down_lane
    import fpn_pkg::*;
(
    input  logic [SP_W-1:0]           src,
    input  logic [1:0]                mbits,
    input  logic signed [SCALE_W-1:0] emin,
    input  logic signed [SCALE_W-1:0] emax,
    input  logic [MAG_W-1:0]          maxmag,
    input  logic                      relu,
    output nar_t                      res
);
    localparam int SIG_W = SP_MAN_W + 1;
    localparam int EXT_W = 2 * SIG_W;
    localparam int SH_CAP = 30;

    sp_t                      x;
    logic                     is_nan, is_inf, is_tiny, over;
    logic signed [SCALE_W-1:0] unb, te, shf, tdiff;
    logic [4:0]               sh;
    logic [EXT_W-1:0]         ext;
    logic [MAG_W-1:0]         kept, rnd;
    logic                     guard, sticky;
    logic [7:0]               code;
    logic [EXT_W-SIG_W-MAG_W-1:0] top_unused;
    nar_t                     pre;

    assign x       = sp_t'(src);
    assign is_nan  = (x.exp == '1) && (x.man != '0);
    assign is_inf  = (x.exp == '1) && (x.man == '0);
    assign is_tiny = (x.exp == '0);

    always_comb begin
        unb   = $signed({2'b00, x.exp}) - 10'sd127;
        te    = (unb > emin) ? unb : emin;
        shf   = te - unb + 10'sd23 - $signed({8'b0, mbits});
        sh    = (shf > 10'sd30) ? 5'(SH_CAP) : shf[4:0];
        ext   = {1'b1, x.man, {SIG_W{1'b0}}} >> sh;
        kept  = ext[SIG_W +: MAG_W];
        guard = ext[SIG_W-1];
        sticky = |ext[SIG_W-2:0];
        rnd   = kept + {4'b0, guard & (sticky | kept[0])};
        tdiff = te - emin;
        code  = (8'(tdiff) << mbits) + {3'b0, rnd};
        over  = is_inf || (unb > emax) || (code > {3'b0, maxmag});
    end

    assign top_unused = ext[EXT_W-1:SIG_W+MAG_W];

    always_comb begin
        if (is_nan)       pre = '{sign: 1'b0,   mag: maxmag};
        else if (over)    pre = '{sign: x.sign, mag: maxmag};
        else if (is_tiny) pre = '{sign: x.sign, mag: '0};
        else              pre = '{sign: x.sign, mag: code[MAG_W-1:0]};
        res = (relu && pre.sign) ? '0 : pre;
    end

endmodule

// File: rtl/fpn_up_lane.sv
module fpn_up_lane
    import fpn_pkg::*;
(
    input  logic                 sign,
    input  logic [MAG_W-1:0]     mag,
    input  logic [1:0]           mbits,
    input  logic [HP_EXP_W-1:0]  hoff,
    input  logic                 relu,
    output logic [HP_W-1:0]      half
);
    logic [MAG_W-1:0]    ef, mf;
    logic                hid;
    logic [HP_MAN_W-1:0] base, n, frac;
    logic [3:0]          p;
    logic [HP_EXP_W-1:0] hexp;

    always_comb begin
        ef   = mag >> mbits;
        mf   = mag & ~(5'h1F << mbits);
        hid  = (ef != '0);
        base = {5'b0, mf} | (10'(hid) << mbits);
        n    = hid ? (base << (ef - 5'd1)) : base;
        p    = msb_pos(n);
        frac = n << (4'd10 - p);
        hexp = {1'b0, p} + hoff;
        if (relu && sign)   half = '0;
        else if (n == '0)   half = {sign, 15'b0};
        else                half = {sign, hexp, frac};
    end

endmodule

// File: rtl/fp_narrow_pack.sv
module fp_narrow_pack
    import fpn_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [1:0]        fmt,
    input  logic              relu,
    input  logic [SP_W-1:0]   src_a,
    input  logic [SP_W-1:0]   src_b,
    input  logic [WORD_W-1:0] pk_in,
    output logic              out_valid,
    output logic [WORD_W-1:0] pk_out,
    output logic [HP_W-1:0]   half_a,
    output logic [HP_W-1:0]   half_b
);
    fmt_desc_t                    desc;
    logic [LANES-1:0][SP_W-1:0]   src_v;
    nar_t                         dres [LANES];
    logic [LANES-1:0][HP_W-1:0]   hres;
    logic [WORD_W-1:0]            pk_next;
    logic                         pad_unused;
    logic                         six_q, relu_q, nan_a;

    assign desc  = fmt_desc(fmt_e'(fmt));
    assign src_v = {src_a, src_b};
    assign pad_unused = ^{pk_in[15:14], pk_in[7:6]};

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        fpn_down_lane u_down (
            .src    (src_v[g]),
            .mbits  (desc.mbits),
            .emin   (desc.emin),
            .emax   (desc.emax),
            .maxmag (desc.maxmag),
            .relu   (relu),
            .res    (dres[g])
        );
        fpn_up_lane u_up (
            .sign  (desc.six ? pk_in[8*g+5] : pk_in[4*g+3]),
            .mag   (desc.six ? pk_in[8*g +: 5] : {2'b00, pk_in[4*g +: 3]}),
            .mbits (desc.mbits),
            .hoff  (desc.hoff),
            .relu  (relu),
            .half  (hres[g])
        );
    end

    always_comb begin
        if (desc.six)
            pk_next = {2'b00, dres[1].sign, dres[1].mag, 2'b00, dres[0].sign, dres[0].mag};
        else
            pk_next = {8'h00, dres[1].sign, dres[1].mag[2:0], dres[0].sign, dres[0].mag[2:0]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            pk_out    <= '0;
            half_a    <= '0;
            half_b    <= '0;
            six_q     <= 1'b0;
            relu_q    <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                pk_out <= pk_next;
                half_a <= hres[1];
                half_b <= hres[0];
                six_q  <= desc.six;
                relu_q <= relu;
            end
        end
    end

    assign nan_a = (src_a[30:23] == 8'hFF) && (src_a[22:0] != '0);

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R1
    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R1
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(pk_out) && $stable(half_a) && $stable(half_b))); // R1
    AST_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (out_valid && six_q) |-> (pk_out[15:14] == 2'b00 && pk_out[7:6] == 2'b00)); // R2
    AST_NIB_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !six_q) |-> (pk_out[15:8] == 8'h00)); // R3
    AST_NAN_POS_MAX: assert property (@(posedge clk) disable iff (rst)
        (in_valid && nan_a) |=> (six_q ? (pk_out[13:8] == {1'b0, $past(desc.maxmag)})
                                       : (pk_out[7:4] == {1'b0, $past(desc.maxmag[2:0])}))); // R6
    AST_RELU_NONNEG: assert property (@(posedge clk) disable iff (rst)
        (out_valid && relu_q) |-> (!half_a[15] && !half_b[15] &&
            (six_q ? (!pk_out[13] && !pk_out[5]) : (!pk_out[7] && !pk_out[3])))); // R7

endmodule

// File: tb/fp_narrow_pack_tb_top.sv
module fp_narrow_pack_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [1:0]  fmt = 2'd0;
    logic        relu = 1'b0;
    logic [31:0] src_a = '0, src_b = '0;
    logic [15:0] pk_in = '0;
    logic        out_valid;
    logic [15:0] pk_out, half_a, half_b;

    always #5 clk = ~clk;

    fp_narrow_pack dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .fmt(fmt), .relu(relu),
        .src_a(src_a), .src_b(src_b), .pk_in(pk_in),
        .out_valid(out_valid), .pk_out(pk_out), .half_a(half_a), .half_b(half_b)
    );

    typedef struct {
        logic [15:0] w;
        logic [15:0] ha;
        logic [15:0] hb;
        string       tw;
    } exp_t;

    exp_t        sb_q[$];
    int          n_chk = 0;
    int          n_fail = 0;
    logic [15:0] last_w = '0;
    bit          finished = 1'b0;

    task automatic chk(string tag, logic [15:0] act, logic [15:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    function automatic real p2(int k);
        real r = 1.0;
        if (k >= 0) for (int i = 0; i < k; i++) r = r * 2.0;
        else        for (int i = 0; i < -k; i++) r = r * 0.5;
        return r;
    endfunction

    function automatic void fparm(int f, output int e, output int m, output int b);
        if (f == 0)      begin e = 2; m = 3; b = 1; end
        else if (f == 1) begin e = 3; m = 2; b = 3; end
        else             begin e = 2; m = 1; b = 1; end
    endfunction

    function automatic real code_val(int mag, int f);
        int e, m, b, ef, mf;
        fparm(f, e, m, b);
        ef = mag >> m;
        mf = mag & ((1 << m) - 1);
        if (ef == 0) return real'(mf) * p2(1 - b - m);
        return (1.0 + real'(mf) * p2(-m)) * p2(ef - b);
    endfunction

    function automatic real rabs(real v);
        return (v < 0.0) ? -v : v;
    endfunction

    // returns {sign, mag[4:0]}
    function automatic logic [5:0] ref_down(logic [31:0] x, int f, bit r);
        int e, m, b, mx, best;
        real v, d, bd;
        logic s;
        fparm(f, e, m, b);
        mx = (1 << (e + m)) - 1;
        s = x[31];
        if (x[30:23] == 8'hFF && x[22:0] != 0) return {1'b0, 5'(mx)};
        if (x[30:23] == 8'hFF) best = mx;
        else begin
            if (x[30:23] == 0) v = real'(x[22:0]) * p2(-149);
            else v = (1.0 + real'(x[22:0]) * p2(-23)) * p2(int'(x[30:23]) - 127);
            if (v > code_val(mx, f)) best = mx;
            else begin
                best = 0;
                bd = v;
                for (int k = 1; k <= mx; k++) begin
                    d = rabs(v - code_val(k, f));
                    if (d < bd || (d == bd && (k % 2) == 0)) begin
                        best = k;
                        bd = d;
                    end
                end
            end
        end
        if (r && s) return 6'd0;
        return {s, 5'(best)};
    endfunction

    function automatic logic [15:0] ref_up(logic s, int mag, int f, bit r);
        real v, fr;
        int k;
        if (r && s) return 16'h0000;
        v = code_val(mag, f);
        if (v == 0.0) return {s, 15'b0};
        k = -20;
        while (p2(k + 1) <= v) k++;
        fr = v / p2(k) - 1.0;
        return {s, 5'(k + 15), 10'(int'(fr * 1024.0))};
    endfunction

    task automatic send(logic [31:0] a, logic [31:0] bv, int f, bit r, logic [15:0] pk, string tg);
        exp_t e;
        logic [5:0] ca, cb;
        bit six;
        @(negedge clk);
        src_a = a; src_b = bv; fmt = 2'(f); relu = r; pk_in = pk; in_valid = 1'b1;
        six = (f < 2);
        ca = ref_down(a, f, r);
        cb = ref_down(bv, f, r);
        if (six) e.w = {2'b00, ca, 2'b00, cb};
        else     e.w = {8'h00, ca[5], ca[2:0], cb[5], cb[2:0]};
        if (six) begin
            e.ha = ref_up(pk[13], int'(pk[12:8]), f, r);
            e.hb = ref_up(pk[5],  int'(pk[4:0]),  f, r);
        end else begin
            e.ha = ref_up(pk[7], int'(pk[6:4]), f, r);
            e.hb = ref_up(pk[3], int'(pk[2:0]), f, r);
        end
        e.tw = {six ? "R2 " : "R3 ", tg, r ? " R7" : ""};
        last_w = e.w;
        sb_q.push_back(e);
    endtask

    always @(negedge clk) begin
        if (!rst && out_valid) begin
            exp_t e;
            if (sb_q.size() == 0) chk("R1 output without request", 16'h1, 16'h0);
            else begin
                e = sb_q.pop_front();
                chk(e.tw, pk_out, e.w);
                chk("R8 half_a", half_a, e.ha);
                chk("R8 half_b", half_b, e.hb);
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        n_chk++;
        n_fail++;
        $display("FAIL R1 watchdog expired actual=running expected=done");
        finish_run();
    end

    logic [31:0] dv [22] = '{32'h3F800000, 32'hBF800000, 32'h40F00000, 32'h40F80000,
                             32'h41E00000, 32'h41F00000, 32'h40C00000, 32'h40A00000,
                             32'h3D800000, 32'h3E400000, 32'h3E800000, 32'h7FC00000,
                             32'hFFC00000, 32'h7F800000, 32'hFF800000, 32'h501502F9,
                             32'hC0533333, 32'h0DA24260, 32'h80000000, 32'h00000000,
                             32'h00000001, 32'h3F400000};
    string dt [22] = '{"R4", "R4", "R5", "R5", "R5", "R5", "R5", "R4", "R4", "R4", "R4",
                       "R6", "R6", "R5", "R5", "R5", "R4", "R9", "R9", "R9", "R9", "R4"};

    initial begin
        repeat (3) @(negedge clk);
        chk("R10 out_valid in reset", {15'b0, out_valid}, 16'h0);
        chk("R10 pk_out in reset", pk_out, 16'h0);
        chk("R10 half_a in reset", half_a, 16'h0);
        chk("R10 half_b in reset", half_b, 16'h0);
        rst = 1'b0;
        for (int f = 0; f < 4; f++)
            for (int r = 0; r < 2; r++)
                for (int i = 0; i < 22; i++)
                    send(dv[i], dv[(i + 5) % 22], f, r[0], 16'($urandom), dt[i]);
        for (int i = 0; i < 300; i++) begin
            logic [31:0] a, bv;
            a  = {1'($urandom), 8'($urandom_range(135, 118)), 23'($urandom)};
            bv = {1'($urandom), 8'($urandom_range(135, 118)), 23'($urandom)};
            send(a, bv, i % 4, 1'(i / 4 % 2), 16'($urandom), "R4");
        end
        @(negedge clk);
        in_valid = 1'b0;
        src_a = 32'h7FC00000;
        src_b = 32'hFF800000;
        fmt = 2'd0;
        pk_in = 16'hFFFF;
        repeat (4) @(negedge clk);
        chk("R1 queue drained", 16'(sb_q.size()), 16'h0);
        chk("R1 pk_out held while idle", pk_out, last_w);
        chk("R1 out_valid low while idle", {15'b0, out_valid}, 16'h0);
        finish_run();
    end

endmodule